// File: doc/BRIEF.md
# Dual-Compare Timer Counter

An 8-bit up-counter that advances by one on every cycle in which the tick strobe is high. Two compare units each hold an 8-bit value, which is checked against the counter whenever a tick is taken. A hit latches a sticky flag for that unit and flips that unit's waveform pin. A wrap from 255 to 0 latches an overflow flag. Each flag can drive an interrupt line through its own enable bit.

Software reaches the counter, both compare values, the flag bits and the enable bits over a simple synchronous bus. The bus has an address, a write strobe, write data and combinational read data. Loading the counter suppresses compare detection on the next tick that is taken. This means a value written equal to a compare setting does not produce a false hit. When a bus write to the counter and a tick land in the same cycle, the write takes effect and the tick is discarded.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter, both compare values, all flags, all enables, both waveform pins and all interrupt lines are zero.
- R2: Address 0 reads the counter. A write to address 0 loads it. With no write, the counter rises by one only on cycles where tick is high, and otherwise holds.
- R3: Addresses 1 and 2 hold compare values A and B. On a taken tick where the counter equals a unit's compare value, and that unit is not masked, the unit's flag is set and its waveform pin toggles. Compare A uses flag bit 0 and wave_out[0]. Compare B uses flag bit 1 and wave_out[1].
- R4: Address 3 reads the flags: bit 0 is A, bit 1 is B, bit 2 is overflow. Writing a 1 to a bit clears that flag. Writing a 0 leaves it unchanged. A set in the same cycle wins over a clear.
- R5: Address 4 holds the enables, using the same bit positions as the flags. cmp_irq[i] is compare flag i ANDed with its enable, and ovf_irq is flag bit 2 ANDed with enable bit 2.
- R6: A counter write masks compare detection in both units on the next taken tick only. The tick after that compares normally.
- R7: A counter write in the same cycle as a tick loads the written value, the tick is lost, and the following tick is masked.
- R8: A taken tick at count 255 wraps the counter to 0 and sets the overflow flag.
- R9: The two compare units act independently. A hit on one leaves the other unit's flag and pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count strobe, one step per high cycle |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cmp_irq | output | 2 | Compare interrupt lines, bit 0 is A, bit 1 is B |
| ovf_irq | output | 1 | Overflow interrupt line |
| wave_out | output | 2 | Toggling waveform pins, bit 0 is A, bit 1 is B |

## Verification
A software load of the counter and a tick can occur in the same cycle. The bench provokes this by raising tick and the counter write strobe on the same clock edge. It then judges the result by reading back exactly the written value, not that value plus one. The bench then takes one more tick with compare B set to the written value and confirms that neither flag B nor its pin moves. The counter's next read must be one above the written value.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 3;
    localparam int N_CMP  = 2;
    localparam int N_FLG  = N_CMP + 1;
    localparam int OVF_BIT = N_CMP;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_COUNT = 3'd0,
        REG_CMP_A = 3'd1,
        REG_CMP_B = 3'd2,
        REG_FLAGS = 3'd3,
        REG_IRQEN = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic adv;   // tick accepted this cycle
        logic wrap;  // accepted tick at terminal count
        logic mask;  // compares suppressed on this tick
    } tick_evt_t;

    localparam cnt_t CNT_MAX = {CNT_W{1'b1}};

    function automatic cnt_t cnt_step(cnt_t c);
        return c + cnt_t'(1);
    endfunction
endpackage

// File: rtl/dct_counter.sv
module dct_counter
    import dct_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      wr_en,
    input  cnt_t      wr_data,
    output cnt_t      cnt,
    output tick_evt_t evt
);
    logic blk_q;

    always_comb begin
        evt.adv  = tick & ~wr_en;
        evt.mask = blk_q;
        evt.wrap = evt.adv & (cnt == CNT_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            blk_q <= 1'b0;
        end else if (wr_en) begin
            cnt   <= wr_data;
            blk_q <= 1'b1;
        end else if (evt.adv) begin
            cnt   <= cnt_step(cnt);
            blk_q <= 1'b0;
        end
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(cnt));

    // R7
    wr_win_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt == $past(wr_data)));

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && cnt == CNT_MAX) |=> (cnt == '0));
endmodule

// File: rtl/dct_cmp_unit.sv
module dct_cmp_unit
    import dct_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  cnt_t      wdata,
    input  cnt_t      cnt,
    input  tick_evt_t evt,
    output cnt_t      cmp_q,
    output logic      hit,
    output logic      wave
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (we) begin
            cmp_q <= wdata;
        end
    end

    assign hit = evt.adv & ~evt.mask & (cnt == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            wave <= 1'b0;
        end else if (hit) begin
            wave <= ~wave;
        end
    end

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.adv && evt.mask) |=> $stable(wave));

    // R3
    hit_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> (wave != $past(wave)));
endmodule

// File: rtl/dct_flags.sv
module dct_flags
    import dct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_FLG-1:0] set,
    input  logic             clr_we,
    input  logic             en_we,
    input  logic [N_FLG-1:0] wdata,
    output logic [N_FLG-1:0] flags,
    output logic [N_FLG-1:0] en,
    output logic [N_FLG-1:0] irq
);
    logic [N_FLG-1:0] clr_mask;

    assign clr_mask = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            en    <= '0;
        end else begin
            flags <= (flags & ~clr_mask) | set;
            if (en_we) begin
                en <= wdata;
            end
        end
    end

    assign irq = flags & en;

    // R4
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((flags & $past(wdata & ~set)) == '0));

    // R4
    set_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> ((flags & $past(set)) == $past(set)));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import dct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [N_CMP-1:0]  cmp_irq,
    output logic              ovf_irq,
    output logic [N_CMP-1:0]  wave_out
);
    localparam logic [ADDR_W-1:0] CMP_BASE = REG_CMP_A;

    cnt_t             cnt;
    tick_evt_t        evt;
    cnt_t             cmp_vals [N_CMP];
    logic [N_CMP-1:0] hits;
    logic [N_FLG-1:0] flags, en, irq;
    logic             cnt_we;

    assign cnt_we = bus_we && (bus_addr == REG_COUNT);

    dct_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (cnt_we),
        .wr_data (bus_wdata),
        .cnt     (cnt),
        .evt     (evt)
    );

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        dct_cmp_unit u_cmp (
            .clk   (clk),
            .rst   (rst),
            .we    (bus_we && (bus_addr == CMP_BASE + ADDR_W'(i))),
            .wdata (bus_wdata),
            .cnt   (cnt),
            .evt   (evt),
            .cmp_q (cmp_vals[i]),
            .hit   (hits[i]),
            .wave  (wave_out[i])
        );
    end

    dct_flags u_flg (
        .clk    (clk),
        .rst    (rst),
        .set    ({evt.wrap, hits}),
        .clr_we (bus_we && (bus_addr == REG_FLAGS)),
        .en_we  (bus_we && (bus_addr == REG_IRQEN)),
        .wdata  (bus_wdata[N_FLG-1:0]),
        .flags  (flags),
        .en     (en),
        .irq    (irq)
    );

    assign cmp_irq = irq[N_CMP-1:0];
    assign ovf_irq = irq[OVF_BIT];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == REG_COUNT) begin
            bus_rdata = cnt;
        end else if (bus_addr == REG_FLAGS) begin
            bus_rdata = CNT_W'(flags);
        end else if (bus_addr == REG_IRQEN) begin
            bus_rdata = CNT_W'(en);
        end
        for (int i = 0; i < N_CMP; i++) begin
            if (bus_addr == CMP_BASE + ADDR_W'(i)) begin
                bus_rdata = cmp_vals[i];
            end
        end
    end

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> (cmp_irq == '0 && !ovf_irq));
endmodule

// File: tb/sim_dual_cmp_timer.sv
`timescale 1ns/1ps
module sim_dual_cmp_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] cmp_irq;
    logic       ovf_irq;
    logic [1:0] wave_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] exp_wave = 2'b00;

    always #2.5 clk = ~clk;

    dual_cmp_timer u0 (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .wave_out(wave_out)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic ticks(int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset;
        int v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 register", v, 0);
        end
        chk("R1 wave", int'(wave_out), 0);
        chk("R1 irq", int'({ovf_irq, cmp_irq}), 0);
    endtask

    task automatic t_count;
        int v;
        wr(3'd1, 8'd5);
        wr(3'd2, 8'd200);
        rd(3'd0, v);
        chk("R2 hold without tick", v, 0);
        ticks(3);
        rd(3'd0, v);
        chk("R2 count", v, 3);
    endtask

    task automatic t_match_a;
        int v;
        ticks(3);              // counts 3,4,5 -> hit at 5
        exp_wave[0] = ~exp_wave[0];
        rd(3'd0, v);
        chk("R3 count after match", v, 6);
        rd(3'd3, v);
        chk("R3 flag A", v, 1);
        chk("R3 wave", int'(wave_out), int'(exp_wave));
        chk("R5 irq disabled", int'(cmp_irq), 0);
    endtask

    task automatic t_irq_clear;
        int v;
        wr(3'd4, 8'd1);
        chk("R5 irq A enabled", int'(cmp_irq), 1);
        wr(3'd3, 8'd0);
        rd(3'd3, v);
        chk("R4 write zero keeps flag", v, 1);
        wr(3'd3, 8'd1);
        rd(3'd3, v);
        chk("R4 w1c", v, 0);
        chk("R5 irq follows flag", int'(cmp_irq), 0);
    endtask

    task automatic t_mask;
        int v;
        wr(3'd0, 8'd5);
        ticks(1);
        rd(3'd0, v);
        chk("R6 count steps", v, 6);
        rd(3'd3, v);
        chk("R6 masked flag", v, 0);
        chk("R6 masked wave", int'(wave_out), int'(exp_wave));
    endtask

    task automatic t_mask_once;
        int v;
        wr(3'd0, 8'd4);
        ticks(2);               // 4 masked, then 5 hits
        exp_wave[0] = ~exp_wave[0];
        rd(3'd3, v);
        chk("R6 second tick compares", v, 1);
        chk("R6 second tick wave", int'(wave_out), int'(exp_wave));
        wr(3'd3, 8'd7);
    endtask

    task automatic t_unit_b;
        int v;
        wr(3'd0, 8'd8);
        wr(3'd2, 8'd10);
        ticks(3);               // 8 masked, 9, 10 hits B
        exp_wave[1] = ~exp_wave[1];
        rd(3'd3, v);
        chk("R9 only flag B", v, 2);
        chk("R9 wave", int'(wave_out), int'(exp_wave));
        rd(3'd1, v);
        chk("R9 compare A kept", v, 5);
        wr(3'd3, 8'd7);
    endtask

    task automatic t_write_wins;
        int v;
        wr(3'd2, 8'd100);
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'd100; bus_we = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick = 1'b0;
        rd(3'd0, v);
        chk("R7 write wins", v, 100);
        ticks(1);
        rd(3'd0, v);
        chk("R7 next tick counts", v, 101);
        rd(3'd3, v);
        chk("R7 next tick masked", v, 0);
        chk("R7 wave unchanged", int'(wave_out), int'(exp_wave));
    endtask

    task automatic t_wrap;
        int v;
        wr(3'd0, 8'd254);
        ticks(2);
        rd(3'd0, v);
        chk("R8 wrap to zero", v, 0);
        rd(3'd3, v);
        chk("R8 overflow flag", v, 4);
        chk("R5 ovf irq off", int'(ovf_irq), 0);
        wr(3'd4, 8'd4);
        chk("R5 ovf irq on", int'(ovf_irq), 1);
        chk("R5 cmp irq off", int'(cmp_irq), 0);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_match_a();
        t_irq_clear();
        t_mask();
        t_mask_once();
        t_unit_b();
        t_write_wins();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule